// File: doc/BRIEF.md
# Control-Register Write Exit Judge

This block decides whether a guest's attempt to change a control register must be handed to the monitor. Each request carries an operation code and a source operand. The operation is one of the following: a full write of CR0 or CR4, a task-switch-flag clear, a low-nibble machine-status load, a page-table-base (CR3) write, or a task-priority (CR8) write. The block checks the request against state that the monitor has programmed through a simple configuration write port. That state is a guest/host ownership mask and a read shadow for CR0 and for CR4, a short list of permitted CR3 values with a count, two control bits, a 4-bit priority threshold and a 4-bit priority shadow.

One cycle after each request, the block reports one of three outcomes. A fault-like exit means the write must not take effect. A trap-like exit means a priority write completed but dropped the priority shadow below the threshold. If neither flag is set, the write proceeds. The block holds and updates the priority shadow itself: a priority write that does not fault stores its low four source bits in the shadow. The block does not update any other architectural register, and it does not check the processor mode or the ordering of faults.

Top module: `crw_exit_judge`

## Requirements
- R1: A full CR0 write (req_op 0) or CR4 write (req_op 1) raises a fault-like exit exactly when some bit set in that register's mask has a source bit that differs from the same bit of its shadow; source bits whose mask bit is clear are ignored.
- R2: While the CR0 mask is all zeros, a full CR0 write never exits, whatever the source value.
- R3: A flag clear (req_op 2) raises a fault-like exit exactly when bit 3 is 1 in both the CR0 mask and the CR0 shadow; the source is ignored.
- R4: A low-nibble load (req_op 3) looks only at source bits 3:0. For each of bits 3:1, it exits when the mask bit is set and the source bit differs from the shadow bit.
- R5: For bit 0, a low-nibble load exits only when the mask bit and the source bit are both 1 and the shadow bit is 0. A 0 source bit over a set shadow bit never exits.
- R6: A CR3 write (req_op 4) raises a fault-like exit unless the source equals one of targets 0 to n-1, where n is the stored count. With n = 0, every CR3 write exits.
- R7: Writing a count above NUM_TGT (default 4) stores NUM_TGT, so all targets become eligible.
- R8: When control bit 0 is 1, a CR8 write (req_op 5) raises a fault-like exit and never a trap-like one.
- R9: When control bit 0 is 0 and control bit 1 is 1, a CR8 write raises a trap-like exit when its new value (source bits 3:0) is below the threshold and also below the current priority shadow. When control bit 1 is 0, a CR8 write never exits.
- R10: A CR8 write without a fault-like exit loads the priority shadow with source bits 3:0. A faulting CR8 write leaves the shadow unchanged. In the same cycle, a CR8 write takes precedence over a configuration write to the shadow.
- R11: rsp_valid is asserted in exactly the cycle after each request. The fault-like and trap-like flags are never both set. Operation codes 6 and 7 never exit.
- R12: The configuration addresses are: 0 for the CR0 mask, 1 for the CR0 shadow, 2 for the CR4 mask, 3 for the CR4 shadow, 4 for the count, 5 for the controls, 6 for the threshold, 7 for the priority shadow, and 8+i for target i. After reset, all configuration state is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | A guest write request is present |
| req_op | input | 3 | Operation code of the request |
| req_src | input | 32 | Source operand of the request |
| rsp_valid | output | 1 | A judgement is present (one cycle after a request) |
| exit_fault | output | 1 | Fault-like exit: the write must not take effect |
| exit_trap | output | 1 | Trap-like exit after a completed CR8 write |

## Verification
The bench builds the block with its default parameters: 32-bit operands, four CR3 targets and a 4-bit priority field. With four targets, a count of 9 exercises the clamp, and counts 2 and 3 show that a matching target beyond the count is refused. With the 4-bit priority field, short sequences of CR8 writes can move the shadow above and below the threshold. In these sequences, a faulting write in the middle proves that the shadow was kept.

// File: rtl/crw_pkg.sv
package crw_pkg;
   typedef enum logic [2:0] {
      OP_CR0_WR = 3'd0,
      OP_CR4_WR = 3'd1,
      OP_CLTS   = 3'd2,
      OP_LMSW   = 3'd3,
      OP_CR3_WR = 3'd4,
      OP_CR8_WR = 3'd5
   } crw_op_e;

   localparam int unsigned A_CR0_MASK = 0;
   localparam int unsigned A_CR0_SHD  = 1;
   localparam int unsigned A_CR4_MASK = 2;
   localparam int unsigned A_CR4_SHD  = 3;
   localparam int unsigned A_TGT_CNT  = 4;
   localparam int unsigned A_CTRL     = 5;
   localparam int unsigned A_PRIO_THR = 6;
   localparam int unsigned A_PRIO_SHD = 7;
   localparam int unsigned A_TGT_BASE = 8;

   localparam int unsigned CTRL_CR8_EXIT = 0;
   localparam int unsigned CTRL_PRIO_EN  = 1;
endpackage

// File: rtl/crw_cfg_regs.sv
module crw_cfg_regs
   import crw_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NUM_TGT = 4,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ADDR_W  = 4,
   localparam int unsigned CNT_W  = $clog2(NUM_TGT + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [ADDR_W-1:0]              cfg_addr,
   input  logic [XLEN-1:0]                cfg_wdata,
   output logic [XLEN-1:0]                cr0_mask,
   output logic [XLEN-1:0]                cr0_shd,
   output logic [XLEN-1:0]                cr4_mask,
   output logic [XLEN-1:0]                cr4_shd,
   output logic [CNT_W-1:0]               tgt_cnt,
   output logic [NUM_TGT-1:0][XLEN-1:0]   tgt_val,
   output logic                           cr8_exit_en,
   output logic                           prio_en,
   output logic [PRIO_W-1:0]              prio_thr
);
   function automatic logic hit(input int unsigned a);
      return cfg_we && (cfg_addr == ADDR_W'(a));
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr0_mask    <= '0;
         cr0_shd     <= '0;
         cr4_mask    <= '0;
         cr4_shd     <= '0;
         tgt_cnt     <= '0;
         cr8_exit_en <= 1'b0;
         prio_en     <= 1'b0;
         prio_thr    <= '0;
      end else begin
         if (hit(A_CR0_MASK)) cr0_mask <= cfg_wdata;
         if (hit(A_CR0_SHD))  cr0_shd  <= cfg_wdata;
         if (hit(A_CR4_MASK)) cr4_mask <= cfg_wdata;
         if (hit(A_CR4_SHD))  cr4_shd  <= cfg_wdata;
         if (hit(A_TGT_CNT)) begin
            if (cfg_wdata > XLEN'(NUM_TGT)) tgt_cnt <= CNT_W'(NUM_TGT);
            else                            tgt_cnt <= cfg_wdata[CNT_W-1:0];
         end
         if (hit(A_CTRL)) begin
            cr8_exit_en <= cfg_wdata[CTRL_CR8_EXIT];
            prio_en     <= cfg_wdata[CTRL_PRIO_EN];
         end
         if (hit(A_PRIO_THR)) prio_thr <= cfg_wdata[PRIO_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  tgt_val[i] <= '0;
         else if (hit(A_TGT_BASE + i)) tgt_val[i] <= cfg_wdata;
      end
   end
endmodule

// File: rtl/crw_mask_judge.sv
module crw_mask_judge
   import crw_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [2:0]      op,
   input  logic [XLEN-1:0] src,
   input  logic [XLEN-1:0] cr0_mask,
   input  logic [XLEN-1:0] cr0_shd,
   input  logic [XLEN-1:0] cr4_mask,
   input  logic [XLEN-1:0] cr4_shd,
   output logic            exit_o
);
   localparam int unsigned TS_BIT = 3;
   localparam int unsigned NIB_W  = 4;

   logic [XLEN-1:0]  cr0_diff, cr4_diff;
   logic [NIB_W-1:1] nib_diff;
   logic             pe_set;

   assign cr0_diff = (src ^ cr0_shd) & cr0_mask;
   assign cr4_diff = (src ^ cr4_shd) & cr4_mask;
   assign nib_diff = (src[NIB_W-1:1] ^ cr0_shd[NIB_W-1:1]) & cr0_mask[NIB_W-1:1];
   // the nibble load can set bit 0 but never clear it
   assign pe_set   = cr0_mask[0] & src[0] & ~cr0_shd[0];

   always_comb begin
      unique case (op)
         OP_CR0_WR: exit_o = |cr0_diff;
         OP_CR4_WR: exit_o = |cr4_diff;
         OP_CLTS:   exit_o = cr0_mask[TS_BIT] & cr0_shd[TS_BIT];
         OP_LMSW:   exit_o = (|nib_diff) | pe_set;
         default:   exit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/crw_tgt_match.sv
module crw_tgt_match #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NUM_TGT = 4,
   localparam int unsigned CNT_W  = $clog2(NUM_TGT + 1)
) (
   input  logic [XLEN-1:0]              src,
   input  logic [CNT_W-1:0]             cnt,
   input  logic [NUM_TGT-1:0][XLEN-1:0] tgt_val,
   output logic                         miss
);
   logic [NUM_TGT-1:0] hit;

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_cmp
      assign hit[i] = (CNT_W'(i) < cnt) && (tgt_val[i] == src);
   end

   assign miss = ~|hit;
endmodule

// File: rtl/crw_prio_track.sv
module crw_prio_track #(
   parameter int unsigned PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [PRIO_W-1:0] new_val,
   input  logic              cr8_exit_en,
   input  logic              prio_en,
   input  logic [PRIO_W-1:0] prio_thr,
   input  logic              cfg_ld,
   input  logic [PRIO_W-1:0] cfg_val,
   output logic              fault_o,
   output logic              trap_o
);
   logic [PRIO_W-1:0] shd_q;

   assign fault_o = wr_fire & cr8_exit_en;
   assign trap_o  = wr_fire & ~cr8_exit_en & prio_en &
                    (new_val < prio_thr) & (new_val < shd_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       shd_q <= '0;
      else if (wr_fire && !cr8_exit_en) shd_q <= new_val;
      else if (cfg_ld)                  shd_q <= cfg_val;
   end
endmodule

// File: rtl/crw_exit_judge.sv
module crw_exit_judge
   import crw_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NUM_TGT = 4,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [XLEN-1:0]   cfg_wdata,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [XLEN-1:0]   req_src,
   output logic              rsp_valid,
   output logic              exit_fault,
   output logic              exit_trap
);
   localparam int unsigned CNT_W = $clog2(NUM_TGT + 1);

   if (NUM_TGT < 1) begin : g_bad_tgt
      $error("NUM_TGT must be at least 1");
   end
   if (XLEN < 8 || PRIO_W > XLEN || PRIO_W < 1) begin : g_bad_width
      $error("XLEN must be >= 8 and PRIO_W in 1..XLEN");
   end
   if (A_TGT_BASE + NUM_TGT > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the target list");
   end

   logic [XLEN-1:0]              cr0_mask, cr0_shd, cr4_mask, cr4_shd;
   logic [CNT_W-1:0]             tgt_cnt;
   logic [NUM_TGT-1:0][XLEN-1:0] tgt_val;
   logic                         cr8_exit_en, prio_en;
   logic [PRIO_W-1:0]            prio_thr;
   logic                         mask_exit, cr3_miss, cr8_fault, cr8_trap;
   logic                         fault_c;

   crw_cfg_regs #(
      .XLEN(XLEN), .NUM_TGT(NUM_TGT), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cr0_mask(cr0_mask), .cr0_shd(cr0_shd),
      .cr4_mask(cr4_mask), .cr4_shd(cr4_shd), .tgt_cnt(tgt_cnt),
      .tgt_val(tgt_val), .cr8_exit_en(cr8_exit_en), .prio_en(prio_en),
      .prio_thr(prio_thr)
   );

   crw_mask_judge #(.XLEN(XLEN)) i_mask (
      .op(req_op), .src(req_src), .cr0_mask(cr0_mask), .cr0_shd(cr0_shd),
      .cr4_mask(cr4_mask), .cr4_shd(cr4_shd), .exit_o(mask_exit)
   );

   crw_tgt_match #(.XLEN(XLEN), .NUM_TGT(NUM_TGT)) i_tgt (
      .src(req_src), .cnt(tgt_cnt), .tgt_val(tgt_val), .miss(cr3_miss)
   );

   crw_prio_track #(.PRIO_W(PRIO_W)) i_prio (
      .clk(clk), .rst_n(rst_n),
      .wr_fire(req_valid && (req_op == OP_CR8_WR)),
      .new_val(req_src[PRIO_W-1:0]), .cr8_exit_en(cr8_exit_en),
      .prio_en(prio_en), .prio_thr(prio_thr),
      .cfg_ld(cfg_we && (cfg_addr == ADDR_W'(A_PRIO_SHD))),
      .cfg_val(cfg_wdata[PRIO_W-1:0]),
      .fault_o(cr8_fault), .trap_o(cr8_trap)
   );

   always_comb begin
      unique case (req_op)
         OP_CR3_WR: fault_c = cr3_miss;
         OP_CR8_WR: fault_c = cr8_fault;
         default:   fault_c = mask_exit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         exit_fault <= 1'b0;
         exit_trap  <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         exit_fault <= req_valid & fault_c;
         exit_trap  <= req_valid & cr8_trap;
      end
   end
endmodule

// File: rtl/crw_exit_judge_chk.sv
module crw_exit_judge_chk
   import crw_pkg::*;
#(
   parameter int unsigned NUM_TGT = 4,
   parameter int unsigned CNT_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [2:0]       req_op,
   input logic             rsp_valid,
   input logic             exit_fault,
   input logic             exit_trap,
   input logic [CNT_W-1:0] tgt_cnt,
   input logic             cr8_exit_en
);
   p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(exit_fault && exit_trap));
   p_flag_needs_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_fault || exit_trap) |-> rsp_valid);
   p_trap_only_cr8_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op != OP_CR8_WR) |=> !exit_trap);
   p_cr3_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_CR3_WR && tgt_cnt == '0) |=> exit_fault);
   p_cr8_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_CR8_WR && cr8_exit_en) |=> (exit_fault && !exit_trap));
   p_cnt_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_cnt <= CNT_W'(NUM_TGT));
endmodule

bind crw_exit_judge crw_exit_judge_chk #(.NUM_TGT(NUM_TGT), .CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .rsp_valid(rsp_valid), .exit_fault(exit_fault), .exit_trap(exit_trap),
   .tgt_cnt(tgt_cnt), .cr8_exit_en(cr8_exit_en)
);

// File: tb/test_crw_exit_judge.sv
module test_crw_exit_judge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [31:0] req_src = '0;
   logic        rsp_valid, exit_fault, exit_trap;

   always #(CLK_PERIOD/2) clk = ~clk;

   crw_exit_judge i_crw_exit_judge (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_op(req_op),
      .req_src(req_src), .rsp_valid(rsp_valid), .exit_fault(exit_fault),
      .exit_trap(exit_trap)
   );

   typedef struct {
      int    cyc;
      logic  f;
      logic  t;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;

   always @(posedge clk) cyc++;

   // monitor: pops the item issued in the previous cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (q.size() > 0 && q[0].cyc == cyc - 1) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (!(rsp_valid === 1'b1 && exit_fault === e.f && exit_trap === e.t)) begin
               n_fail++;
               $display("FAIL %s: valid/fault/trap = %b%b%b, expected 1%b%b",
                        e.tag, rsp_valid, exit_fault, exit_trap, e.f, e.t);
            end
         end else if (rsp_valid !== 1'b0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11: unexpected response valid=%b, expected 0", rsp_valid);
         end
      end
   end

   task automatic cfg(input int a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [2:0] op, input logic [31:0] src,
                       input logic ef, input logic et, input string tag);
      exp_t e;
      req_valid = 1'b1; req_op = op; req_src = src;
      e.cyc = cyc; e.f = ef; e.t = et; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if ({rsp_valid, exit_fault, exit_trap} !== 3'b000) begin
         n_fail++;
         $display("FAIL R12: outputs in reset %b, expected 000",
                  {rsp_valid, exit_fault, exit_trap});
      end
      rst_n = 1'b1;
      @(negedge clk);

      // reset configuration: zero mask, zero count
      send(3'd0, 32'hFFFF_FFFF, 0, 0, "R2 zero mask CR0 write");
      send(3'd4, 32'h0000_0000, 1, 0, "R6 count 0 CR3 write");

      // CR0 / CR4 masked compare
      cfg(0, 32'h0000_0021); cfg(1, 32'h0000_0001);
      send(3'd0, 32'h0000_0001, 0, 0, "R1 CR0 match");
      send(3'd0, 32'h0000_0021, 1, 0, "R1 CR0 bit5 differs");
      send(3'd0, 32'hFFFF_FFDF, 0, 0, "R1 CR0 unmasked bits ignored");
      send(3'd0, 32'h0000_0000, 1, 0, "R1 CR0 bit0 differs");
      cfg(2, 32'h0000_2000); cfg(3, 32'h0000_2000);
      send(3'd1, 32'h0000_2000, 0, 0, "R1 CR4 match");
      send(3'd1, 32'h0000_0000, 1, 0, "R1 CR4 differs");

      // flag clear
      send(3'd2, 32'hFFFF_FFFF, 0, 0, "R3 mask bit3 clear");
      cfg(0, 32'h0000_0008); cfg(1, 32'h0000_0008);
      send(3'd2, 32'h0000_0000, 1, 0, "R3 mask and shadow bit3 set");
      cfg(1, 32'h0000_0000);
      send(3'd2, 32'h0000_0000, 0, 0, "R3 shadow bit3 clear");

      // low-nibble load
      cfg(0, 32'h0000_000F); cfg(1, 32'h0000_0005);
      send(3'd3, 32'h0000_0005, 0, 0, "R4 nibble match");
      send(3'd3, 32'h0000_0007, 1, 0, "R4 bit1 differs");
      send(3'd3, 32'h0000_0004, 0, 0, "R5 bit0 cannot be cleared");
      cfg(1, 32'h0000_0004);
      send(3'd3, 32'h0000_0005, 1, 0, "R5 bit0 set over clear shadow");
      send(3'd3, 32'hFFFF_FFF4, 0, 0, "R4 upper source bits ignored");
      cfg(0, 32'h0000_000E);
      send(3'd3, 32'h0000_0005, 0, 0, "R5 bit0 unmasked");

      // CR3 target list
      cfg(8, 32'h0000_1000); cfg(9, 32'h0000_2000);
      cfg(10, 32'h0000_3000); cfg(11, 32'h0000_4000);
      cfg(4, 2);
      send(3'd4, 32'h0000_2000, 0, 0, "R6 target 1 within count 2");
      send(3'd4, 32'h0000_3000, 1, 0, "R6 target 2 beyond count 2");
      cfg(4, 4);
      send(3'd4, 32'h0000_4000, 0, 0, "R6 target 3 within count 4");
      cfg(4, 3);
      send(3'd4, 32'h0000_4000, 1, 0, "R6 target 3 beyond count 3");
      cfg(4, 9);
      send(3'd4, 32'h0000_4000, 0, 0, "R7 count 9 clamped to 4");
      send(3'd4, 32'h0000_5000, 1, 0, "R7 no target matches");

      // CR8 writes
      cfg(5, 32'h1);
      send(3'd5, 32'h0000_0002, 1, 0, "R8 load-exit set");
      cfg(5, 32'h2); cfg(6, 8); cfg(7, 10);
      send(3'd5, 32'h0000_0009, 0, 0, "R9 above threshold");
      send(3'd5, 32'h0000_0005, 1'b0, 1'b1, "R9 drops below threshold");
      cfg(7, 10);
      cfg(5, 32'h3);
      send(3'd5, 32'h0000_0002, 1, 0, "R8 load-exit wins over trap");
      cfg(5, 32'h2);
      send(3'd5, 32'h0000_0005, 1'b0, 1'b1, "R10 faulting write kept shadow");
      send(3'd5, 32'h0000_0007, 0, 0, "R10 shadow updated to 5");
      send(3'd5, 32'hFFFF_FFF1, 1'b0, 1'b1, "R9 low bits only, 1 below 7");
      cfg(5, 32'h0);
      send(3'd5, 32'h0000_0000, 0, 0, "R9 compare disabled");

      // unused codes and back-to-back
      cfg(0, 32'hFFFF_FFFF); cfg(1, 32'h0);
      send(3'd6, 32'hFFFF_FFFF, 0, 0, "R11 code 6");
      send(3'd7, 32'hFFFF_FFFF, 0, 0, "R11 code 7");
      send(3'd0, 32'h0000_0001, 1, 0, "R11 back-to-back A");
      send(3'd0, 32'h0000_0000, 0, 0, "R11 back-to-back B");

      repeat (3) @(negedge clk);
      n_chk++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R11: %0d responses missing, expected 0", q.size());
      end
      summary();
   end
endmodule